// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block takes the two open-collector lines of a PS/2 keyboard, clock and data, and turns each 11-bit frame into a byte for the system. Both lines pass through two-flop synchronizers. The synchronized keyboard clock is watched for falling edges, and the data line is sampled on each one. A four-phase machine steps through idle, data bits, parity bit and stop bit. Each good byte appears on an 8-bit code output, together with a one-cycle valid strobe.

Two mechanisms keep the receiver aligned with the keyboard. The first is an inactivity timer, derived from the system clock frequency, which is re-armed on every accepted bit. If the timer runs out while a frame is in progress, the machine goes back to idle and drops the partial byte. The second is the odd-parity check. A failed check drops the frame and pulses a request, so that a separate host transmitter sends the resend command to the keyboard. While the transmitter or the output stage asserts a hold input, the receiver ignores the keyboard lines.

Top module: `ps2_frame_rx`

## Requirements
- R1: After reset, `code_valid_o` and `resend_req_o` are 0, `code_o` is 0x00, and the receiver is in idle, so it treats the next falling edge with data 0 as a start bit. `resend_cmd_o` is always 0xFE.
- R2: Data bits are sampled on falling edges of the keyboard clock, least significant bit first. When the stop bit's falling edge is accepted, `code_o` takes the byte and `code_valid_o` is high for exactly one cycle. This happens on the third rising system clock edge after the keyboard clock goes low.
- R3: In idle, a falling edge with the data line at 1 is not a start bit. It is ignored, and a frame that follows it is received correctly.
- R4: The eight data bits plus the parity bit must hold an odd number of ones. A frame that meets this is accepted.
- R5: On a parity mismatch, the byte is discarded, `code_valid_o` stays 0, `resend_req_o` pulses for one cycle, and the machine returns to idle.
- R6: If no falling edge is accepted for CLK_HZ/1e6*TIMEOUT_US system cycles while a frame is in progress, the machine returns to idle and drops the partial byte. The next complete frame is then received intact.
- R7: Falling edges that arrive while `hold_i` is 1 are ignored. A full frame sent under hold produces neither a valid strobe nor a resend request.
- R8: `code_valid_o` and `resend_req_o` are never high in the same cycle, and neither is high for two consecutive cycles.
- R9: The value of the stop bit is not checked. The byte is emitted at the stop bit's falling edge even if the data line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kb_clk_i | input | 1 | Keyboard clock line (asynchronous) |
| kb_dat_i | input | 1 | Keyboard data line (asynchronous) |
| hold_i | input | 1 | When 1, keyboard line activity is ignored |
| code_o | output | 8 | Last received byte |
| code_valid_o | output | 1 | One-cycle strobe for a new byte on code_o |
| resend_req_o | output | 1 | One-cycle request to send the resend command |
| resend_cmd_o | output | 8 | Command byte for the transmitter (0xFE) |

## Verification
A falling edge of the keyboard clock takes effect on the third rising system edge after the line drops. Two of those edges belong to the synchronizer and one to the output register. So the valid strobe and the resend request are high during the cycle after that third edge. The latency scenario samples at the falling system edge after the second, third and fourth rising edges, and expects 0, 1 and 0 in turn. The other scenarios space the keyboard bits tens of cycles apart. Between each stimulus and the next, they compare the counts of strobes and requests and the last captured byte. The timeout scenario waits well beyond the configured window before sending the next frame.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DATA   = 2'd1,
    PH_PARITY = 2'd2,
    PH_STOP   = 2'd3
  } rx_phase_e;
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] line_i,
  output logic [WIDTH-1:0] line_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, stable_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= 1'b1;
        stable_q <= 1'b1;
      end else begin
        meta_q   <= line_i[g];
        stable_q <= meta_q;
      end
    end
    assign line_o[g] = stable_q;
  end
endmodule

// File: rtl/ps2_idle_timer.sv
module ps2_idle_timer #(
  parameter int CLK_HZ     = 2_000_000,
  parameter int TIMEOUT_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int TMO_CYC = (CLK_HZ / 1_000_000) * TIMEOUT_US;
  localparam int CW      = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire_o = run_i && !kick_i && (cnt_q == LAST);
  assign cnt_en   = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (kick_i || !run_i || expire_o) cnt_d = '0;
    else                              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ps2_rx_fsm.sv
module ps2_rx_fsm
  import ps2_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall_i,
  input  logic                 dat_i,
  input  logic                 expire_i,
  output rx_phase_e            phase_o,
  output logic [DATA_BITS-1:0] code_o,
  output logic                 valid_o,
  output logic                 resend_o
);
  localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

  rx_phase_e            ph_q, ph_d;
  logic [DATA_BITS-1:0] sh_q, sh_d, code_q, code_d;
  logic [BW-1:0]        bit_q, bit_d;
  logic                 par_q, par_d;
  logic                 val_q, val_d, rsd_q, rsd_d;

  always_comb begin
    ph_d   = ph_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    par_d  = par_q;
    code_d = code_q;
    val_d  = 1'b0;
    rsd_d  = 1'b0;
    if (expire_i) begin
      ph_d  = PH_IDLE;
      sh_d  = '0;
      bit_d = '0;
      par_d = 1'b0;
    end else if (fall_i) begin
      unique case (ph_q)
        PH_IDLE: begin
          if (!dat_i) begin
            ph_d  = PH_DATA;
            sh_d  = '0;
            bit_d = '0;
            par_d = 1'b0;
          end
        end
        PH_DATA: begin
          sh_d  = {dat_i, sh_q[DATA_BITS-1:1]};
          par_d = par_q ^ dat_i;
          if (bit_q == LAST_BIT) ph_d = PH_PARITY;
          else                   bit_d = bit_q + 1'b1;
        end
        PH_PARITY: begin
          if (par_q ^ dat_i) begin
            ph_d = PH_STOP;
          end else begin
            ph_d  = PH_IDLE;
            sh_d  = '0;
            rsd_d = 1'b1;
          end
        end
        PH_STOP: begin
          ph_d   = PH_IDLE;
          code_d = sh_q;
          val_d  = 1'b1;
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      sh_q   <= '0;
      bit_q  <= '0;
      par_q  <= 1'b0;
      code_q <= '0;
      val_q  <= 1'b0;
      rsd_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      par_q  <= par_d;
      code_q <= code_d;
      val_q  <= val_d;
      rsd_q  <= rsd_d;
    end
  end

  assign phase_o  = ph_q;
  assign code_o   = code_q;
  assign valid_o  = val_q;
  assign resend_o = rsd_q;
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_rx_pkg::*;
#(
  parameter int CLK_HZ     = 250_000_000,
  parameter int TIMEOUT_US = 100,
  parameter logic [7:0] RESEND_CMD = 8'hFE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kb_clk_i,
  input  logic       kb_dat_i,
  input  logic       hold_i,
  output logic [7:0] code_o,
  output logic       code_valid_o,
  output logic       resend_req_o,
  output logic [7:0] resend_cmd_o
);
  logic [1:0] lines_s;
  logic       kclk_s, kdat_s, kclk_prev_q;
  logic       fall_w, take_w, tmo_w;
  rx_phase_e  phase_w;

  ps2_line_sync #(.WIDTH(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i ({kb_dat_i, kb_clk_i}),
    .line_o (lines_s)
  );
  assign kclk_s = lines_s[0];
  assign kdat_s = lines_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kclk_prev_q <= 1'b1;
    else        kclk_prev_q <= kclk_s;
  end

  assign fall_w = kclk_prev_q && !kclk_s;
  assign take_w = fall_w && !hold_i;

  ps2_idle_timer #(.CLK_HZ(CLK_HZ), .TIMEOUT_US(TIMEOUT_US)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (phase_w != PH_IDLE),
    .kick_i   (take_w),
    .expire_o (tmo_w)
  );

  ps2_rx_fsm #(.DATA_BITS(8)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_i   (take_w),
    .dat_i    (kdat_s),
    .expire_i (tmo_w),
    .phase_o  (phase_w),
    .code_o   (code_o),
    .valid_o  (code_valid_o),
    .resend_o (resend_req_o)
  );

  assign resend_cmd_o = RESEND_CMD;
endmodule

// File: rtl/ps2_frame_rx_chk.sv
module ps2_frame_rx_chk
  import ps2_rx_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      hold_i,
  input logic      code_valid_o,
  input logic      resend_req_o,
  input logic      tmo_w,
  input rx_phase_e phase_w
);
  // R8: strobes one cycle wide and mutually exclusive
  assert_valid_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid_o |=> !code_valid_o);
  assert_resend_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resend_req_o |=> !resend_req_o);
  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(code_valid_o && resend_req_o));
  // R2: a byte is only emitted out of the stop phase
  assert_valid_from_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_valid_o) |-> $past(phase_w) == PH_STOP);
  // R5: resend only follows the parity phase and lands in idle
  assert_resend_from_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resend_req_o) |-> ($past(phase_w) == PH_PARITY && phase_w == PH_IDLE));
  // R6: expiry returns to idle
  assert_timeout_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_w |=> phase_w == PH_IDLE);
  // R7: an edge under hold never produces a strobe
  assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (!code_valid_o && !resend_req_o));
endmodule

bind ps2_frame_rx ps2_frame_rx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hold_i       (hold_i),
  .code_valid_o (code_valid_o),
  .resend_req_o (resend_req_o),
  .tmo_w        (tmo_w),
  .phase_w      (phase_w)
);

// File: tb/ps2_frame_rx_tb_top.sv
`timescale 1ns/1ps
module ps2_frame_rx_tb_top;
  localparam int CLK_HZ = 2_000_000;
  localparam int TMO_US = 100;
  localparam int TMO_CYC = (CLK_HZ / 1_000_000) * TMO_US;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kb_clk = 1'b1, kb_dat = 1'b1, hold = 1'b0;
  logic [7:0] code, rcmd;
  logic valid, resend;

  int n_chk = 0, n_fail = 0;
  int n_valid = 0, n_resend = 0, n_width = 0, n_overlap = 0;
  logic [7:0] last_code = 8'h00;
  logic prev_valid = 1'b0, prev_resend = 1'b0;
  bit watch_on = 1'b0;

  always #2 clk = ~clk;

  ps2_frame_rx #(.CLK_HZ(CLK_HZ), .TIMEOUT_US(TMO_US)) dut_i (
    .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk), .kb_dat_i(kb_dat),
    .hold_i(hold), .code_o(code), .code_valid_o(valid),
    .resend_req_o(resend), .resend_cmd_o(rcmd)
  );

  always @(negedge clk) begin
    if (watch_on) begin
      if (valid) begin n_valid++; last_code = code; end
      if (resend) n_resend++;
      if ((valid && prev_valid) || (resend && prev_resend)) n_width++;
      if (valid && resend) n_overlap++;
    end
    prev_valid  = valid;
    prev_resend = resend;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    kb_dat = b;
    wait_cyc(10);
    kb_clk = 1'b0;
    wait_cyc(20);
    kb_clk = 1'b1;
    wait_cyc(10);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input logic stop_v);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit((~^d) ^ bad_par);
    send_bit(stop_v);
    wait_cyc(8);
  endtask

  task automatic expect_byte(input logic [7:0] d, input string req);
    int v0 = n_valid, r0 = n_resend;
    send_frame(d, 1'b0, 1'b1);
    check(n_valid == v0 + 1, req, n_valid - v0, 1);
    check(last_code == d, req, last_code, d);
    check(n_resend == r0, req, n_resend - r0, 0);
  endtask

  task automatic t_reset;
    check(valid == 1'b0, "R1", valid, 0);
    check(resend == 1'b0, "R1", resend, 0);
    check(code == 8'h00, "R1", code, 0);
    check(rcmd == 8'hFE, "R1", rcmd, 8'hFE);
  endtask

  task automatic t_basic;
    expect_byte(8'h1C, "R2");
    expect_byte(8'hA5, "R4");
    expect_byte(8'h00, "R4");
    expect_byte(8'hFF, "R4");
    expect_byte(8'h80, "R2");
  endtask

  task automatic t_latency;
    logic [7:0] d = 8'h5A;
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(~^d);
    @(negedge clk);
    kb_dat = 1'b1;
    wait_cyc(10);
    kb_clk = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(valid == 1'b0, "R2 latency edge2", valid, 0);
    @(negedge clk);
    check(valid == 1'b1, "R2 latency edge3", valid, 1);
    check(code == 8'h5A, "R2 latency code", code, 8'h5A);
    @(negedge clk);
    check(valid == 1'b0, "R2 pulse width", valid, 0);
    wait_cyc(18);
    kb_clk = 1'b1;
    wait_cyc(10);
  endtask

  task automatic t_start_high;
    int v0 = n_valid;
    send_bit(1'b1);
    check(n_valid == v0, "R3 stray edge", n_valid - v0, 0);
    expect_byte(8'h6B, "R3");
  endtask

  task automatic t_bad_parity;
    int v0 = n_valid, r0 = n_resend;
    send_frame(8'h3C, 1'b1, 1'b1);
    check(n_resend == r0 + 1, "R5 resend", n_resend - r0, 1);
    check(n_valid == v0, "R5 no byte", n_valid - v0, 0);
    expect_byte(8'h33, "R5 recovery");
  endtask

  task automatic t_timeout;
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    wait_cyc(TMO_CYC + 50);
    expect_byte(8'h29, "R6");
  endtask

  task automatic t_hold;
    int v0, r0;
    hold = 1'b1;
    v0 = n_valid; r0 = n_resend;
    send_frame(8'h12, 1'b0, 1'b1);
    check(n_valid == v0, "R7 hold byte", n_valid - v0, 0);
    send_frame(8'h12, 1'b1, 1'b1);
    check(n_resend == r0, "R7 hold resend", n_resend - r0, 0);
    hold = 1'b0;
    expect_byte(8'h44, "R7 after hold");
  endtask

  task automatic t_stop_zero;
    int v0 = n_valid;
    send_frame(8'hC3, 1'b0, 1'b0);
    check(n_valid == v0 + 1, "R9 stop zero", n_valid - v0, 1);
    check(last_code == 8'hC3, "R9 code", last_code, 8'hC3);
    kb_dat = 1'b1;
    wait_cyc(5);
  endtask

  initial begin
    wait_cyc(5);
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    watch_on = 1'b1;
    wait_cyc(5);
    t_basic;
    t_latency;
    t_start_high;
    t_bad_parity;
    t_timeout;
    t_hold;
    t_stop_zero;
    check(n_width == 0, "R8 width", n_width, 0);
    check(n_overlap == 0, "R8 overlap", n_overlap, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(150_000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule